// File: doc/BRIEF.md
# Two-Digit Decimal Sum Calculator

This block holds two single-digit decimal operands, each set by a pushbutton, and presents their sum in decimal as a units digit and a tens digit covering 0 to 18. Each operand is a decade counter. It advances by one each time its button is released, after the raw button level has been synchronized and debounced against the system clock. The two operand values enter a 4-bit binary adder that also produces a carry.

The binary result is converted to decimal in two separate steps. When the adder carry is set, which happens only for sums of 16 to 18, a second add stage adds six to the low nibble. A fixed boolean remap of the upper three bits then folds any nibble value from 10 to 15 down to 0 to 5. The tens digit is set by either the carry or a folded nibble.

All four digits (operand A, operand B, sum units, sum tens) are also presented as active-low seven-segment patterns, ready to drive common-anode displays.

Top module: `decsum_top`

## Requirements
- R1: Each operand counts 0,1,...,9 and the step that follows 9 returns it to 0. It never holds a value above 9.
- R2: An operand advances only when its debounced button goes from pressed (1) to released (0). Holding the button pressed leaves the operand unchanged.
- R3: A button level that holds for fewer than STABLE_CYCLES clock cycles after synchronization is ignored and does not change the operand.
- R4: While the synchronous active-high reset `rst` is sampled high, both operands are cleared to 0, so every output digit reads 0.
- R5: For every operand pair, 10*`sum_tens` + `sum_units` equals `opa_digit` + `opb_digit`. This includes 16, 17 and 18, which must not wrap.
- R6: A sum from 10 to 15 gives `sum_tens` = 1 and `sum_units` = sum - 10.
- R7: Each seven-segment output is active low, with bit 0 = segment a through bit 6 = segment g. The digits 0 to 9 show the standard glyphs (active-high gfedcba codes 3F,06,5B,4F,66,6D,7D,07,7F,6F). `seg_tens` shows the glyph for 0 or 1.
- R8: `sum_units` is always a valid BCD digit (0 to 9).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_a | input | 1 | Raw button for operand A, 1 while pressed |
| btn_b | input | 1 | Raw button for operand B, 1 while pressed |
| opa_digit | output | 4 | Operand A, BCD |
| opb_digit | output | 4 | Operand B, BCD |
| sum_units | output | 4 | Units digit of the sum, BCD |
| sum_tens | output | 1 | Tens digit of the sum (0 or 1) |
| seg_a | output | 7 | Active-low segments for operand A |
| seg_b | output | 7 | Active-low segments for operand B |
| seg_units | output | 7 | Active-low segments for the sum units |
| seg_tens | output | 7 | Active-low segments for the sum tens |

## Verification
The only state is in the operand counters and the debouncers, so a wrong internal state shows up at the operand digit outputs within the debounce window plus three clock cycles after a release. The sum and segment outputs are purely combinational from those counters. Any error in the add-6 or remap logic therefore appears in the same cycle as the operand pair that exposes it. Stepping through all 100 pairs exposes such an error at the first affected pair, and the carry path is reached first at 7+9.

// File: rtl/dsum_pkg.sv
package dsum_pkg;

    localparam int DIGIT_W = 4;
    localparam int SEG_W   = 7;
    localparam int RADIX   = 10;

    typedef logic [DIGIT_W-1:0] bcd_t;
    typedef logic [SEG_W-1:0]   seg_t;

    typedef struct packed {
        logic carry;
        bcd_t nib;
    } bin_sum_t;

    typedef struct packed {
        logic tens;
        bcd_t units;
    } dec_sum_t;

    // Next value of a decade counter.
    function automatic bcd_t digit_next(input bcd_t d);
        return (d >= bcd_t'(RADIX - 1)) ? '0 : d + bcd_t'(1);
    endfunction

    // Active-low glyph, bit 0 = a .. bit 6 = g; non-digits are blank.
    function automatic seg_t seg_glyph(input bcd_t d);
        seg_t on;
        case (d)
            4'd0:    on = 7'h3F;
            4'd1:    on = 7'h06;
            4'd2:    on = 7'h5B;
            4'd3:    on = 7'h4F;
            4'd4:    on = 7'h66;
            4'd5:    on = 7'h6D;
            4'd6:    on = 7'h7D;
            4'd7:    on = 7'h07;
            4'd8:    on = 7'h7F;
            4'd9:    on = 7'h6F;
            default: on = 7'h00;
        endcase
        return ~on;
    endfunction

endpackage

// File: rtl/dsum_debounce.sv
module dsum_debounce #(
    parameter int SYNC_STAGES   = 2,
    parameter int STABLE_CYCLES = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic btn_raw,
    output logic release_pulse
);
    localparam int CNT_W = $clog2(STABLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STABLE_CYCLES - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CNT_W-1:0]       cnt_q;
    logic                   level_q;
    logic                   level_d1_q;
    logic                   btn_s;

    assign btn_s = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q     <= '0;
            cnt_q      <= '0;
            level_q    <= 1'b0;
            level_d1_q <= 1'b0;
        end else begin
            sync_q     <= {sync_q[SYNC_STAGES-2:0], btn_raw};
            level_d1_q <= level_q;
            if (btn_s == level_q) begin
                cnt_q <= '0;
            end else if (cnt_q == CNT_LAST) begin
                cnt_q   <= '0;
                level_q <= btn_s;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign release_pulse = level_d1_q & ~level_q;

endmodule

// File: rtl/dsum_operand.sv
module dsum_operand
    import dsum_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic step,
    output bcd_t digit
);
    bcd_t digit_q;

    always_ff @(posedge clk) begin
        if (rst)       digit_q <= '0;
        else if (step) digit_q <= digit_next(digit_q);
    end

    assign digit = digit_q;

endmodule

// File: rtl/dsum_correct.sv
module dsum_correct
    import dsum_pkg::*;
(
    input  bcd_t     opa,
    input  bcd_t     opb,
    output dec_sum_t result
);
    bin_sum_t raw;
    bcd_t     fixed;
    logic     b0, b1, b2, b3;

    // Stage 1: plain binary add with carry.
    assign raw = bin_sum_t'({1'b0, opa} + {1'b0, opb});

    // Stage 2: add six only when stage 1 carried (sums 16..18).
    assign fixed = raw.nib + (raw.carry ? bcd_t'(6) : bcd_t'(0));

    assign {b3, b2, b1, b0} = fixed;

    // Fold 10..15 to 0..5; 0..9 pass unchanged.
    always_comb begin
        result.units[0] = b0;
        result.units[1] = (~b3 & b1) | (b3 & b2 & ~b1);
        result.units[2] = (~b3 & b2) | (b2 & b1);
        result.units[3] = b3 & ~b2 & ~b1;
        result.tens     = raw.carry | (b3 & (b1 | b2));
    end

endmodule

// File: rtl/decsum_top.sv
module decsum_top
    import dsum_pkg::*;
#(
    parameter int SYNC_STAGES   = 2,
    parameter int STABLE_CYCLES = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       btn_a,
    input  logic       btn_b,
    output logic [3:0] opa_digit,
    output logic [3:0] opb_digit,
    output logic [3:0] sum_units,
    output logic       sum_tens,
    output logic [6:0] seg_a,
    output logic [6:0] seg_b,
    output logic [6:0] seg_units,
    output logic [6:0] seg_tens
);
    localparam int N_OPS    = 2;
    localparam int N_DIGITS = 4;

    logic     [N_OPS-1:0] btn_vec;
    logic     [N_OPS-1:0] step_vec;
    bcd_t                 op_digit [N_OPS];
    bcd_t                 disp_digit [N_DIGITS];
    seg_t                 disp_seg [N_DIGITS];
    dec_sum_t             sum;

    assign btn_vec = {btn_b, btn_a};

    for (genvar i = 0; i < N_OPS; i++) begin : g_op
        dsum_debounce #(
            .SYNC_STAGES  (SYNC_STAGES),
            .STABLE_CYCLES(STABLE_CYCLES)
        ) deb_i (
            .clk          (clk),
            .rst          (rst),
            .btn_raw      (btn_vec[i]),
            .release_pulse(step_vec[i])
        );

        dsum_operand cnt_i (
            .clk  (clk),
            .rst  (rst),
            .step (step_vec[i]),
            .digit(op_digit[i])
        );
    end

    dsum_correct corr_i (
        .opa   (op_digit[0]),
        .opb   (op_digit[1]),
        .result(sum)
    );

    assign disp_digit[0] = op_digit[0];
    assign disp_digit[1] = op_digit[1];
    assign disp_digit[2] = sum.units;
    assign disp_digit[3] = {3'b000, sum.tens};

    for (genvar d = 0; d < N_DIGITS; d++) begin : g_seg
        assign disp_seg[d] = seg_glyph(disp_digit[d]);
    end

    assign opa_digit = op_digit[0];
    assign opb_digit = op_digit[1];
    assign sum_units = sum.units;
    assign sum_tens  = sum.tens;
    assign seg_a     = disp_seg[0];
    assign seg_b     = disp_seg[1];
    assign seg_units = disp_seg[2];
    assign seg_tens  = disp_seg[3];

endmodule

// File: rtl/dsum_checker.sv
module dsum_checker (
    input logic       clk,
    input logic       rst,
    input logic [3:0] opa_digit,
    input logic [3:0] opb_digit,
    input logic [3:0] sum_units,
    input logic       sum_tens,
    input logic [6:0] seg_tens
);
    logic past_ok = 1'b0;

    always_ff @(posedge clk) past_ok <= ~rst;

    // R1: any change of an operand is a single decade step.
    p_wrap_step_r1: assert property (@(posedge clk) disable iff (rst)
        past_ok && (opa_digit != $past(opa_digit)) |->
            opa_digit == (($past(opa_digit) == 4'd9) ? 4'd0 : $past(opa_digit) + 4'd1));

    // R4: the cycle after a reset edge shows cleared operands.
    p_reset_clear_r4: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (opa_digit == 4'd0) && (opb_digit == 4'd0));

    // R5: decimal reading equals the arithmetic sum.
    p_decimal_sum_r5: assert property (@(posedge clk) disable iff (rst)
        ((sum_tens ? 5'd10 : 5'd0) + {1'b0, sum_units}) ==
        ({1'b0, opa_digit} + {1'b0, opb_digit}));

    // R8: units digit stays in BCD range.
    p_units_range_r8: assert property (@(posedge clk) disable iff (rst)
        sum_units <= 4'd9);

    // R7: tens display is the active-low glyph of 1 when set.
    p_tens_glyph_r7: assert property (@(posedge clk) disable iff (rst)
        sum_tens |-> seg_tens == 7'b1111001);

endmodule

bind decsum_top dsum_checker chk_i (
    .clk      (clk),
    .rst      (rst),
    .opa_digit(opa_digit),
    .opb_digit(opb_digit),
    .sum_units(sum_units),
    .sum_tens (sum_tens),
    .seg_tens (seg_tens)
);

// File: tb/decsum_top_tb_top.sv
module decsum_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int STABLE     = 4;
    localparam int SETTLE     = 12;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       btn_a = 1'b0;
    logic       btn_b = 1'b0;
    logic [3:0] opa_digit, opb_digit, sum_units;
    logic       sum_tens;
    logic [6:0] seg_a, seg_b, seg_units, seg_tens;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    decsum_top #(.SYNC_STAGES(2), .STABLE_CYCLES(STABLE)) dut_i (
        .clk(clk), .rst(rst), .btn_a(btn_a), .btn_b(btn_b),
        .opa_digit(opa_digit), .opb_digit(opb_digit),
        .sum_units(sum_units), .sum_tens(sum_tens),
        .seg_a(seg_a), .seg_b(seg_b), .seg_units(seg_units), .seg_tens(seg_tens)
    );

    function automatic logic [6:0] glyph(input int d);
        logic [6:0] on;
        case (d)
            0: on = 7'h3F; 1: on = 7'h06; 2: on = 7'h5B; 3: on = 7'h4F;
            4: on = 7'h66; 5: on = 7'h6D; 6: on = 7'h7D; 7: on = 7'h07;
            8: on = 7'h7F; 9: on = 7'h6F; default: on = 7'h00;
        endcase
        return ~on;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic press(input bit which_b);
        if (which_b) btn_b = 1'b1; else btn_a = 1'b1;
        repeat (SETTLE) @(negedge clk);
        if (which_b) btn_b = 1'b0; else btn_a = 1'b0;
        repeat (SETTLE) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk); rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        check("R4 opa after reset", opa_digit, 0);
        check("R4 opb after reset", opb_digit, 0);
        check("R4 units after reset", sum_units, 0);
        check("R4 tens after reset", sum_tens, 0);
    endtask

    task automatic t_press_vs_release();
        btn_a = 1'b1;
        repeat (SETTLE) @(negedge clk);
        check("R2 held press no step", opa_digit, 0);
        btn_a = 1'b0;
        repeat (SETTLE) @(negedge clk);
        check("R2 step on release", opa_digit, 1);
    endtask

    task automatic t_glitch();
        btn_b = 1'b1;
        repeat (STABLE - 2) @(negedge clk);
        btn_b = 1'b0;
        repeat (SETTLE) @(negedge clk);
        check("R3 short pulse ignored", opb_digit, 0);
        btn_b = 1'b1;
        @(negedge clk);
        btn_b = 1'b0;
        repeat (SETTLE) @(negedge clk);
        check("R3 one-cycle pulse ignored", opb_digit, 0);
    endtask

    task automatic t_reset_midway();
        press(1'b1); press(1'b1);
        check("R4 setup opb", opb_digit, 2);
        do_reset();
        check("R4 opa cleared midway", opa_digit, 0);
        check("R4 opb cleared midway", opb_digit, 0);
    endtask

    task automatic t_all_pairs();
        for (int a = 0; a < 10; a++) begin
            for (int b = 0; b < 10; b++) begin
                int s;
                s = a + b;
                check("R1 opa value", opa_digit, a);
                check("R1 opb value", opb_digit, b);
                check("R5 tens", sum_tens, s / 10);
                check("R5 units", sum_units, s % 10);
                if (s >= 10 && s <= 15) begin
                    check("R6 folded units", sum_units, s - 10);
                    check("R6 tens set", sum_tens, 1);
                end
                check("R8 units bcd", (sum_units <= 4'd9) ? 1 : 0, 1);
                check("R7 seg_a", seg_a, glyph(a));
                check("R7 seg_b", seg_b, glyph(b));
                check("R7 seg_units", seg_units, glyph(s % 10));
                check("R7 seg_tens", seg_tens, glyph(s / 10));
                press(1'b1);
            end
            check("R1 opb wraps to 0", opb_digit, 0);
            press(1'b0);
        end
        check("R1 opa wraps to 0", opa_digit, 0);
    endtask

    initial begin
        t_reset();
        t_press_vs_release();
        t_glitch();
        t_reset_midway();
        t_all_pairs();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule